// File: doc/BRIEF.md
# Dual-Address Operand Transfer Sequencer

This block moves one operand for each accepted transfer request from a source port to a destination port. The operand passes through an internal 16-bit holding register. One side is memory and the other is a device. Each side is either 8 or 16 bits wide, and the operand is a byte or a word. The operand is read in as many bus cycles as the source width needs, then written in as many cycles as the destination width needs. All cycles of one operand run back to back.

Two address pointers and a transfer counter are loaded together while the sequencer is idle. The memory pointer steps only when memory is accessed, and the device pointer only when the device is accessed. The counter drops once per finished operand. The bus reports a 3-bit termination code for each cycle, and the sequencer reacts to it as follows:

- It reissues a cycle that asks to be retried.
- It parks on a halt or a relinquish request and continues the same operand when the bus is handed back.
- It shuts the channel down on a bus error.

A completion strobe marks each cycle that moved data.

Top module: `opxfer_seq`

## Requirements
- R1: The number of bus cycles per operand is as follows.
  - A byte operand takes 2 cycles.
  - A word operand between two 8-bit sides takes 4 cycles.
  - A word operand between an 8-bit and a 16-bit side takes 3 cycles: 2 on the narrow side and 1 on the wide side.
  - A word operand between two 16-bit sides takes 2 cycles.
- R2: Every read cycle of an operand comes before any of its write cycles. Memory is the source when `cfg_mem_src`=1. `cyc_valid` stays high from the first cycle of an operand to the last, with no idle clock between them.
- R3: A pointer steps only after a successful cycle on its own side. The source pointer steps on reads and the destination pointer steps on writes. The step is 1 for a byte cycle (`cyc_word`=0) and 2 for a word cycle. A pointer whose increment enable is low keeps its value.
- R4: `xfer_count` changes only when the last cycle of an operand terminates successfully. On a normal operand it drops by 1.
- R5: Packed mode applies when `cfg_pack`=1, the operand is a byte, both sides are 16 bits wide, and the remaining count is above 1. In that mode a request moves two bytes as word cycles: pointers step by 2 and the count drops by 2. When the remaining count is 1, the request moves a single byte with byte cycles.
- R6: Termination code 1 (halt) completes the cycle like a normal one, including the strobe and pointer step. The sequencer then raises `st_halted`, issues no cycle until `bus_resume`, and afterwards finishes the same operand.
- R7: Termination code 2 (retry) reissues the same cycle on the next clock. The reissued cycle has the same address and direction, with `cyc_start` pulsing again. There is no strobe, no pointer step and no count change.
- R8: Termination code 3 (relinquish and retry) raises `st_halted` without a strobe or step. After `bus_resume`, the same cycle is run again.
- R9: Termination codes 4 to 7 (bus error) stop the channel and set `st_err`. The count and untouched pointers keep their values, the partly read operand is dropped, and later requests start nothing until a new load.
- R10: `cyc_done` pulses for one clock per cycle terminated with code 0 (normal) or 1, and never for codes 2 to 7.
- R11: Byte cycles carry data on bits 7:0. A word read over two byte cycles puts the first byte in the high half and the second in the low half. Writes present the bytes in the same order, and a word cycle carries all 16 bits.
- R12: `xfer_req` is ignored while an operand is in progress, while halted, after an error, and when the count is zero. `st_done` rises when the count reaches zero. A load is accepted only while idle and clears `st_done` and `st_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_op_word | input | 1 | Operand size: 1 = word, 0 = byte |
| cfg_mem_wide | input | 1 | Memory side is 16 bits wide |
| cfg_dev_wide | input | 1 | Device side is 16 bits wide |
| cfg_mem_src | input | 1 | 1 = memory to device, 0 = device to memory |
| cfg_mem_inc | input | 1 | Memory pointer increment enable |
| cfg_dev_inc | input | 1 | Device pointer increment enable |
| cfg_pack | input | 1 | Two-bytes-per-request mode for byte operands between 16-bit sides |
| ld_en | input | 1 | Load pointers and count (accepted while idle) |
| ld_mem_addr | input | AW | Memory pointer load value |
| ld_dev_addr | input | AW | Device pointer load value |
| ld_count | input | CW | Transfer count load value |
| xfer_req | input | 1 | Operand transfer request |
| bus_resume | input | 1 | Bus handed back after a halt or relinquish |
| term_valid | input | 1 | Current bus cycle terminates this clock |
| term_code | input | 3 | Termination: 0 normal, 1 halt, 2 retry, 3 relinquish and retry, 4-7 bus error |
| rd_data | input | 16 | Read data for the current cycle |
| cyc_valid | output | 1 | A bus cycle is being driven |
| cyc_start | output | 1 | First clock of a (re)issued bus cycle |
| cyc_addr | output | AW | Address of the current cycle |
| cyc_write | output | 1 | Current cycle is a write |
| cyc_dev | output | 1 | Current cycle targets the device side |
| cyc_word | output | 1 | Current cycle is 16 bits wide |
| wr_data | output | 16 | Write data of the current cycle |
| cyc_done | output | 1 | Current cycle terminated successfully |
| mem_ptr | output | AW | Memory pointer |
| dev_ptr | output | AW | Device pointer |
| xfer_count | output | CW | Remaining transfer count |
| st_done | output | 1 | Count reached zero |
| st_err | output | 1 | Channel stopped on a bus error |
| st_halted | output | 1 | Parked, waiting for the bus |

## Verification
The hardest state to reach from the ports is an operand parked halfway. In that state the read side has finished, the holding register carries live data, and new requests arrive. The bench's bus responder takes its termination code from a per-test script indexed by cycle position, so a relinquish, halt, retry or bus error lands on a chosen part of a chosen operand. While the sequencer is parked, the bench sends a request and checks that no cycle appears. It then resumes and checks that the reissued write carries the byte captured before the interruption.

// File: rtl/opxfer_pkg.sv
package opxfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SUSP = 2'd2
  } seq_state_e;

  localparam logic [2:0] TC_NORMAL   = 3'd0;
  localparam logic [2:0] TC_HALT     = 3'd1;
  localparam logic [2:0] TC_RETRY    = 3'd2;
  localparam logic [2:0] TC_RELRETRY = 3'd3;

  // A two-byte operand on a narrow side is split into two byte cycles.
  function automatic logic split_on(input logic side_wide, input logic two_byte);
    return two_byte && !side_wide;
  endfunction

  // A two-byte operand on a wide side moves in one word cycle.
  function automatic logic word_on(input logic side_wide, input logic two_byte);
    return two_byte && side_wide;
  endfunction

  // Pointer step for one cycle.
  function automatic logic [1:0] step_of(input logic word_cyc);
    return word_cyc ? 2'd2 : 2'd1;
  endfunction

  // Count decrement for one operand.
  function automatic logic [1:0] dec_of(input logic op_word, input logic two_byte);
    return (!op_word && two_byte) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/opxfer_plan.sv
module opxfer_plan
  import opxfer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          op_word,
  input  logic          pack,
  input  logic          mem_wide,
  input  logic          dev_wide,
  input  logic          mem_src,
  input  logic [CW-1:0] count,
  output logic          two_byte,
  output logic          rd_split,
  output logic          wr_split,
  output logic          rd_word,
  output logic          wr_word,
  output logic [1:0]    cnt_dec
);

  logic src_wide;
  logic dst_wide;
  logic pack_pair;

  assign src_wide  = mem_src ? mem_wide : dev_wide;
  assign dst_wide  = mem_src ? dev_wide : mem_wide;
  assign pack_pair = pack && !op_word && mem_wide && dev_wide && (count > CW'(1));
  assign two_byte  = op_word || pack_pair;
  assign rd_split  = split_on(src_wide, two_byte);
  assign wr_split  = split_on(dst_wide, two_byte);
  assign rd_word   = word_on(src_wide, two_byte);
  assign wr_word   = word_on(dst_wide, two_byte);
  assign cnt_dec   = dec_of(op_word, two_byte);

endmodule

// File: rtl/opxfer_ptr.sv
module opxfer_ptr
  import opxfer_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic          inc_en,
  input  logic          word_cyc,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load) begin
      ptr_q <= load_val;
    end else if (adv && inc_en) begin
      ptr_q <= ptr_q + AW'(step_of(word_cyc));
    end
  end

  assign ptr = ptr_q;

  // A pointer with increment disabled only changes through a load.
  p_frozen_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !inc_en) |=> $stable(ptr_q));

endmodule

// File: rtl/opxfer_ctrl.sv
module opxfer_ctrl
  import opxfer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [CW-1:0] ld_count,
  input  logic          xfer_req,
  input  logic          bus_resume,
  input  logic          term_valid,
  input  logic [2:0]    term_code,
  input  logic [15:0]   rd_data,
  input  logic          mem_src,
  input  logic          two_byte,
  input  logic          rd_split,
  input  logic          wr_split,
  input  logic          rd_word,
  input  logic          wr_word,
  input  logic [1:0]    cnt_dec,
  output logic          ld_ok,
  output logic          cyc_valid,
  output logic          cyc_start,
  output logic          cyc_write,
  output logic          cyc_dev,
  output logic          cyc_word,
  output logic [15:0]   wr_data,
  output logic          cyc_done,
  output logic          adv_src,
  output logic          adv_dst,
  output logic [CW-1:0] count,
  output logic          st_done,
  output logic          st_err,
  output logic          st_halted
);

  seq_state_e    state_q;
  logic          wr_ph_q;
  logic          part_q;
  logic          first_q;
  logic          pend_q;
  logic          active_q;
  logic          done_q;
  logic          err_q;
  logic [CW-1:0] count_q;
  logic [15:0]   hold_q;

  // Named events for assertions and datapath.
  logic          run;
  logic          t_norm;
  logic          t_halt;
  logic          t_retry;
  logic          t_rel;
  logic          t_err;
  logic          ok_end;
  logic          split_now;
  logic          last_part;
  logic          op_last;
  logic          op_end;
  logic [CW-1:0] count_rem;

  always_comb begin
    run       = (state_q == ST_RUN);
    t_norm    = (term_code == TC_NORMAL);
    t_halt    = (term_code == TC_HALT);
    t_retry   = (term_code == TC_RETRY);
    t_rel     = (term_code == TC_RELRETRY);
    t_err     = term_code[2];
    ok_end    = run && term_valid && (t_norm || t_halt);
    split_now = wr_ph_q ? wr_split : rd_split;
    last_part = !split_now || part_q;
    op_last   = wr_ph_q && last_part;
    op_end    = ok_end && op_last;
    count_rem = count_q - CW'(cnt_dec);
  end

  assign ld_ok     = ld_en && (state_q == ST_IDLE);
  assign cyc_valid = run;
  assign cyc_start = run && first_q;
  assign cyc_write = wr_ph_q;
  assign cyc_dev   = wr_ph_q ? mem_src : !mem_src;
  assign cyc_word  = wr_ph_q ? wr_word : rd_word;
  assign cyc_done  = ok_end;
  assign adv_src   = ok_end && !wr_ph_q;
  assign adv_dst   = ok_end && wr_ph_q;
  assign count     = count_q;
  assign st_done   = done_q;
  assign st_err    = err_q;
  assign st_halted = (state_q == ST_SUSP);

  // Write lane: word cycle takes all 16 bits; byte cycles take the high
  // byte first when the operand is split, otherwise the low byte.
  always_comb begin
    if (wr_word) begin
      wr_data = hold_q;
    end else if (two_byte && !part_q) begin
      wr_data = {8'h00, hold_q[15:8]};
    end else begin
      wr_data = {8'h00, hold_q[7:0]};
    end
  end

  // Holding register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (ld_ok || (run && term_valid && t_err)) begin
      hold_q <= '0;
    end else if (adv_src) begin
      if (rd_word) begin
        hold_q <= rd_data;
      end else if (two_byte && !part_q) begin
        hold_q[15:8] <= rd_data[7:0];
      end else begin
        hold_q[7:0] <= rd_data[7:0];
      end
    end
  end

  // Sequencer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      wr_ph_q  <= 1'b0;
      part_q   <= 1'b0;
      first_q  <= 1'b0;
      pend_q   <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      count_q  <= '0;
    end else begin
      first_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ld_en) begin
            count_q  <= ld_count;
            active_q <= (ld_count != '0);
            done_q   <= 1'b0;
            err_q    <= 1'b0;
          end else if (xfer_req && active_q) begin
            state_q <= ST_RUN;
            wr_ph_q <= 1'b0;
            part_q  <= 1'b0;
            first_q <= 1'b1;
            pend_q  <= 1'b1;
          end
        end
        ST_RUN: begin
          if (term_valid) begin
            if (t_err) begin
              state_q  <= ST_IDLE;
              active_q <= 1'b0;
              err_q    <= 1'b1;
              pend_q   <= 1'b0;
            end else if (t_retry) begin
              first_q <= 1'b1;
            end else if (t_rel) begin
              state_q <= ST_SUSP;
            end else if (op_last) begin
              count_q <= count_rem;
              pend_q  <= 1'b0;
              wr_ph_q <= 1'b0;
              part_q  <= 1'b0;
              state_q <= t_halt ? ST_SUSP : ST_IDLE;
              if (count_rem == '0) begin
                active_q <= 1'b0;
                done_q   <= 1'b1;
              end
            end else begin
              if (last_part) begin
                wr_ph_q <= 1'b1;
                part_q  <= 1'b0;
              end else begin
                part_q <= 1'b1;
              end
              if (t_halt) begin
                state_q <= ST_SUSP;
              end else begin
                first_q <= 1'b1;
              end
            end
          end
        end
        ST_SUSP: begin
          if (bus_resume) begin
            state_q <= pend_q ? ST_RUN : ST_IDLE;
            first_q <= pend_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: a successful non-final normal cycle is followed at once by the next.
  p_back_to_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && term_valid && t_norm && !op_last) |=> (cyc_valid && cyc_start));

  // R2: once writing, no read cycle of the same operand follows.
  p_reads_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_ph_q && !(term_valid && (op_last || t_err))) |=> (wr_ph_q || !run));

  // R4: the count moves only at operand end or on a load.
  p_count_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_end && !ld_ok) |=> $stable(count_q));

  // R7: retry reissues the same part without strobe.
  p_retry_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && term_valid && t_retry) |=> (cyc_start && $stable(wr_ph_q) && $stable(part_q)));

  // R8: relinquish parks the channel without changing progress.
  p_rel_parks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && term_valid && t_rel) |=> (st_halted && $stable(count_q) && $stable(part_q)));

  // R9: a bus error leaves the channel stopped with its error flag.
  p_err_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && term_valid && t_err) |=> (st_err && !cyc_valid && $stable(count_q)));

  // R10: no strobe outside a running cycle.
  p_strobe_in_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> (cyc_valid && term_valid));

endmodule

// File: rtl/opxfer_seq.sv
module opxfer_seq
  import opxfer_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_op_word,
  input  logic          cfg_mem_wide,
  input  logic          cfg_dev_wide,
  input  logic          cfg_mem_src,
  input  logic          cfg_mem_inc,
  input  logic          cfg_dev_inc,
  input  logic          cfg_pack,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_mem_addr,
  input  logic [AW-1:0] ld_dev_addr,
  input  logic [CW-1:0] ld_count,
  input  logic          xfer_req,
  input  logic          bus_resume,
  input  logic          term_valid,
  input  logic [2:0]    term_code,
  input  logic [15:0]   rd_data,
  output logic          cyc_valid,
  output logic          cyc_start,
  output logic [AW-1:0] cyc_addr,
  output logic          cyc_write,
  output logic          cyc_dev,
  output logic          cyc_word,
  output logic [15:0]   wr_data,
  output logic          cyc_done,
  output logic [AW-1:0] mem_ptr,
  output logic [AW-1:0] dev_ptr,
  output logic [CW-1:0] xfer_count,
  output logic          st_done,
  output logic          st_err,
  output logic          st_halted
);

  localparam int NSIDE = 2;  // index 0 = memory, 1 = device

  logic          two_byte;
  logic          rd_split;
  logic          wr_split;
  logic          rd_word;
  logic          wr_word;
  logic [1:0]    cnt_dec;
  logic          ld_ok;
  logic          adv_src;
  logic          adv_dst;
  logic [CW-1:0] count;

  logic [AW-1:0] side_load [NSIDE];
  logic [AW-1:0] side_ptr  [NSIDE];
  logic          side_adv  [NSIDE];
  logic          side_inc  [NSIDE];
  logic          side_word [NSIDE];

  opxfer_plan #(.CW(CW)) u_plan (
    .op_word  (cfg_op_word),
    .pack     (cfg_pack),
    .mem_wide (cfg_mem_wide),
    .dev_wide (cfg_dev_wide),
    .mem_src  (cfg_mem_src),
    .count    (count),
    .two_byte (two_byte),
    .rd_split (rd_split),
    .wr_split (wr_split),
    .rd_word  (rd_word),
    .wr_word  (wr_word),
    .cnt_dec  (cnt_dec)
  );

  opxfer_ctrl #(.CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (ld_en),
    .ld_count   (ld_count),
    .xfer_req   (xfer_req),
    .bus_resume (bus_resume),
    .term_valid (term_valid),
    .term_code  (term_code),
    .rd_data    (rd_data),
    .mem_src    (cfg_mem_src),
    .two_byte   (two_byte),
    .rd_split   (rd_split),
    .wr_split   (wr_split),
    .rd_word    (rd_word),
    .wr_word    (wr_word),
    .cnt_dec    (cnt_dec),
    .ld_ok      (ld_ok),
    .cyc_valid  (cyc_valid),
    .cyc_start  (cyc_start),
    .cyc_write  (cyc_write),
    .cyc_dev    (cyc_dev),
    .cyc_word   (cyc_word),
    .wr_data    (wr_data),
    .cyc_done   (cyc_done),
    .adv_src    (adv_src),
    .adv_dst    (adv_dst),
    .count      (count),
    .st_done    (st_done),
    .st_err     (st_err),
    .st_halted  (st_halted)
  );

  assign side_load[0] = ld_mem_addr;
  assign side_load[1] = ld_dev_addr;
  assign side_inc[0]  = cfg_mem_inc;
  assign side_inc[1]  = cfg_dev_inc;
  assign side_adv[0]  = cfg_mem_src ? adv_src : adv_dst;
  assign side_adv[1]  = cfg_mem_src ? adv_dst : adv_src;
  assign side_word[0] = cfg_mem_src ? rd_word : wr_word;
  assign side_word[1] = cfg_mem_src ? wr_word : rd_word;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    opxfer_ptr #(.AW(AW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_ok),
      .load_val (side_load[s]),
      .adv      (side_adv[s]),
      .inc_en   (side_inc[s]),
      .word_cyc (side_word[s]),
      .ptr      (side_ptr[s])
    );
  end

  assign mem_ptr    = side_ptr[0];
  assign dev_ptr    = side_ptr[1];
  assign cyc_addr   = cyc_dev ? side_ptr[1] : side_ptr[0];
  assign xfer_count = count;

  // R7: the reissued cycle presents the same address.
  p_retry_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && term_valid && term_code == TC_RETRY) |=> (cyc_valid && $stable(cyc_addr)));

  // R3: a failed cycle never moves either pointer.
  p_no_step_on_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && term_valid && !cyc_done) |=> ($stable(mem_ptr) && $stable(dev_ptr)));

endmodule

// File: tb/test_opxfer_seq.sv
module test_opxfer_seq;

  localparam int AW = 24;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_op_word = 1'b0;
  logic          cfg_mem_wide = 1'b0;
  logic          cfg_dev_wide = 1'b0;
  logic          cfg_mem_src = 1'b1;
  logic          cfg_mem_inc = 1'b1;
  logic          cfg_dev_inc = 1'b1;
  logic          cfg_pack = 1'b0;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_mem_addr = '0;
  logic [AW-1:0] ld_dev_addr = '0;
  logic [CW-1:0] ld_count = '0;
  logic          xfer_req = 1'b0;
  logic          bus_resume = 1'b0;
  logic          term_valid = 1'b0;
  logic [2:0]    term_code = 3'd0;
  logic [15:0]   rd_data;
  logic          cyc_valid, cyc_start, cyc_write, cyc_dev, cyc_word, cyc_done;
  logic [AW-1:0] cyc_addr, mem_ptr, dev_ptr;
  logic [15:0]   wr_data;
  logic [CW-1:0] xfer_count;
  logic          st_done, st_err, st_halted;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  opxfer_seq #(.AW(AW), .CW(CW)) i_opxfer_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_op_word(cfg_op_word), .cfg_mem_wide(cfg_mem_wide), .cfg_dev_wide(cfg_dev_wide),
    .cfg_mem_src(cfg_mem_src), .cfg_mem_inc(cfg_mem_inc), .cfg_dev_inc(cfg_dev_inc),
    .cfg_pack(cfg_pack), .ld_en(ld_en), .ld_mem_addr(ld_mem_addr), .ld_dev_addr(ld_dev_addr),
    .ld_count(ld_count), .xfer_req(xfer_req), .bus_resume(bus_resume),
    .term_valid(term_valid), .term_code(term_code), .rd_data(rd_data),
    .cyc_valid(cyc_valid), .cyc_start(cyc_start), .cyc_addr(cyc_addr), .cyc_write(cyc_write),
    .cyc_dev(cyc_dev), .cyc_word(cyc_word), .wr_data(wr_data), .cyc_done(cyc_done),
    .mem_ptr(mem_ptr), .dev_ptr(dev_ptr), .xfer_count(xfer_count),
    .st_done(st_done), .st_err(st_err), .st_halted(st_halted)
  );

  // Bus model read pattern.
  function automatic logic [15:0] pat(input logic [AW-1:0] a, input logic w);
    return w ? {a[7:0], a[7:0] ^ 8'hFF} : {8'h00, a[7:0] ^ 8'h5A};
  endfunction
  assign rd_data = pat(cyc_addr, cyc_word);

  // Responder: terminates every cycle in one clock, code from a script.
  logic [AW-1:0] lg_addr [64];
  logic          lg_wr   [64];
  logic          lg_dev  [64];
  logic          lg_word [64];
  logic [15:0]   lg_data [64];
  int n_log = 0;
  int tcount = 0;
  int starts_tot = 0;
  int done_tot = 0;
  logic [2:0] sc [8];
  int sc_base = 0;
  int sc_n = 0;

  always @(negedge clk) begin
    if (cyc_valid) begin
      lg_addr[n_log % 64] = cyc_addr;
      lg_wr[n_log % 64]   = cyc_write;
      lg_dev[n_log % 64]  = cyc_dev;
      lg_word[n_log % 64] = cyc_word;
      lg_data[n_log % 64] = wr_data;
      starts_tot = starts_tot + int'(cyc_start);
      term_code = ((tcount - sc_base) < sc_n) ? sc[tcount - sc_base] : 3'd0;
      term_valid = 1'b1;
      n_log = n_log + 1;
      tcount = tcount + 1;
      #1;
      if (cyc_done) done_tot = done_tot + 1;
    end else begin
      term_valid = 1'b0;
      term_code = 3'd0;
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_cyc(input string rq, input int idx, input logic [AW-1:0] a,
                         input logic w, input logic d, input logic wd);
    chk(rq, $sformatf("cycle %0d addr", idx), 32'(lg_addr[idx % 64]), 32'(a));
    chk(rq, $sformatf("cycle %0d kind", idx),
        {29'd0, lg_wr[idx % 64], lg_dev[idx % 64], lg_word[idx % 64]}, {29'd0, w, d, wd});
  endtask

  task automatic chk_wdata(input string rq, input int idx, input logic [15:0] exp);
    chk(rq, $sformatf("cycle %0d wdata", idx), 32'(lg_data[idx % 64]), 32'(exp));
  endtask

  task automatic set_cfg(input logic ow, input logic mw, input logic dw, input logic ms,
                         input logic mi, input logic di, input logic pk);
    cfg_op_word = ow; cfg_mem_wide = mw; cfg_dev_wide = dw; cfg_mem_src = ms;
    cfg_mem_inc = mi; cfg_dev_inc = di; cfg_pack = pk;
  endtask

  task automatic script(input logic [2:0] c0, input logic [2:0] c1, input logic [2:0] c2, input int n);
    sc[0] = c0; sc[1] = c1; sc[2] = c2;
    for (int i = 3; i < 8; i++) sc[i] = 3'd0;
    sc_base = tcount;
    sc_n = n;
  endtask

  task automatic load(input logic [AW-1:0] m, input logic [AW-1:0] d, input logic [CW-1:0] c);
    @(negedge clk);
    ld_mem_addr = m; ld_dev_addr = d; ld_count = c; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0;
  endtask

  task automatic pulse_resume();
    @(negedge clk); bus_resume = 1'b1;
    @(negedge clk); bus_resume = 1'b0;
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12", "reset valid", 32'(cyc_valid), 32'd0);
    chk("R12", "reset status", {29'd0, st_done, st_err, st_halted}, 32'd0);
    chk("R4", "reset count", 32'(xfer_count), 32'd0);
  endtask

  task automatic t_byte_narrow();
    int b; int d0;
    set_cfg(0, 0, 0, 1, 1, 1, 0);
    script(0, 0, 0, 0);
    load(24'h000100, 24'h000200, 16'd3);
    b = n_log; d0 = done_tot;
    pulse_req(); idle_wait(8);
    chk("R1", "byte cycles", 32'(n_log - b), 32'd2);
    chk_cyc("R2", b, 24'h000100, 0, 0, 0);
    chk_cyc("R2", b + 1, 24'h000200, 1, 1, 0);
    chk_wdata("R11", b + 1, 16'h005A);
    chk("R3", "mem ptr", 32'(mem_ptr), 32'h101);
    chk("R3", "dev ptr", 32'(dev_ptr), 32'h201);
    chk("R4", "count", 32'(xfer_count), 32'd2);
    chk("R10", "strobes", 32'(done_tot - d0), 32'd2);
  endtask

  task automatic t_word_narrow();
    int b;
    set_cfg(1, 0, 0, 1, 1, 1, 0);
    script(0, 0, 0, 0);
    load(24'h000310, 24'h000420, 16'd2);
    b = n_log;
    pulse_req(); idle_wait(8);
    chk("R1", "word 8/8 cycles", 32'(n_log - b), 32'd4);
    chk_cyc("R2", b, 24'h000310, 0, 0, 0);
    chk_cyc("R2", b + 1, 24'h000311, 0, 0, 0);
    chk_cyc("R2", b + 2, 24'h000420, 1, 1, 0);
    chk_cyc("R2", b + 3, 24'h000421, 1, 1, 0);
    chk_wdata("R11", b + 2, 16'h004A);
    chk_wdata("R11", b + 3, 16'h004B);
    chk("R3", "mem ptr", 32'(mem_ptr), 32'h312);
    chk("R4", "count", 32'(xfer_count), 32'd1);
  endtask

  task automatic t_word_mixed();
    int b;
    set_cfg(1, 1, 0, 0, 0, 1, 0);
    script(0, 0, 0, 0);
    load(24'h000500, 24'h000600, 16'd1);
    b = n_log;
    pulse_req(); idle_wait(8);
    chk("R1", "mixed cycles", 32'(n_log - b), 32'd3);
    chk_cyc("R1", b, 24'h000600, 0, 1, 0);
    chk_cyc("R1", b + 1, 24'h000601, 0, 1, 0);
    chk_cyc("R1", b + 2, 24'h000500, 1, 0, 1);
    chk_wdata("R11", b + 2, 16'h5A5B);
    chk("R3", "mem ptr frozen", 32'(mem_ptr), 32'h500);
    chk("R3", "dev ptr", 32'(dev_ptr), 32'h602);
    chk("R12", "done flag", 32'(st_done), 32'd1);
    b = n_log;
    pulse_req(); idle_wait(6);
    chk("R12", "req at zero count", 32'(n_log - b), 32'd0);
  endtask

  task automatic t_word_wide();
    int b;
    set_cfg(1, 1, 1, 1, 1, 1, 0);
    script(0, 0, 0, 0);
    load(24'h000720, 24'h000840, 16'd2);
    b = n_log;
    pulse_req(); idle_wait(8);
    chk("R1", "wide cycles", 32'(n_log - b), 32'd2);
    chk_cyc("R3", b + 1, 24'h000840, 1, 1, 1);
    chk_wdata("R11", b + 1, 16'h20DF);
    chk("R3", "mem ptr", 32'(mem_ptr), 32'h722);
    chk("R3", "dev ptr", 32'(dev_ptr), 32'h842);
  endtask

  task automatic t_pack();
    int b;
    set_cfg(0, 1, 1, 1, 1, 1, 1);
    script(0, 0, 0, 0);
    load(24'h000900, 24'h000A00, 16'd3);
    b = n_log;
    pulse_req(); idle_wait(8);
    chk("R5", "pack cycles", 32'(n_log - b), 32'd2);
    chk_cyc("R5", b + 1, 24'h000A00, 1, 1, 1);
    chk_wdata("R5", b + 1, 16'h00FF);
    chk("R5", "pack count", 32'(xfer_count), 32'd1);
    chk("R5", "pack mem ptr", 32'(mem_ptr), 32'h902);
    b = n_log;
    pulse_req(); idle_wait(8);
    chk_cyc("R5", b, 24'h000902, 0, 0, 0);
    chk_cyc("R5", b + 1, 24'h000A02, 1, 1, 0);
    chk_wdata("R5", b + 1, 16'h0058);
    chk("R5", "tail ptrs", {mem_ptr[15:0], dev_ptr[15:0]}, 32'h0903_0A03);
    chk("R12", "tail done", {30'd0, st_done, 1'b0} | 32'(xfer_count), 32'd2);
  endtask

  task automatic t_retry();
    int b; int d0; int s0;
    set_cfg(1, 0, 0, 1, 1, 1, 0);
    load(24'h000B10, 24'h000C20, 16'd1);
    script(0, 2, 0, 3);
    b = n_log; d0 = done_tot; s0 = starts_tot;
    pulse_req(); idle_wait(10);
    chk("R7", "retry cycles", 32'(n_log - b), 32'd5);
    chk_cyc("R7", b + 1, 24'h000B11, 0, 0, 0);
    chk_cyc("R7", b + 2, 24'h000B11, 0, 0, 0);
    chk("R7", "starts", 32'(starts_tot - s0), 32'd5);
    chk("R10", "strobes", 32'(done_tot - d0), 32'd4);
    chk_wdata("R11", b + 3, 16'h004A);
    chk("R4", "count", 32'(xfer_count), 32'd0);
  endtask

  task automatic t_relretry();
    int b; int d0;
    set_cfg(0, 0, 0, 1, 1, 1, 0);
    load(24'h000D00, 24'h000E00, 16'd1);
    script(0, 3, 0, 2);
    b = n_log; d0 = done_tot;
    pulse_req(); idle_wait(6);
    chk("R8", "parked", 32'(st_halted), 32'd1);
    chk("R8", "count held", 32'(xfer_count), 32'd1);
    chk("R8", "dst ptr held", 32'(dev_ptr), 32'hE00);
    pulse_req(); idle_wait(4);
    chk("R12", "req while parked", 32'(n_log - b), 32'd2);
    pulse_resume(); idle_wait(6);
    chk("R8", "total cycles", 32'(n_log - b), 32'd3);
    chk_cyc("R8", b + 2, 24'h000E00, 1, 1, 0);
    chk_wdata("R8", b + 2, 16'h005A);
    chk("R10", "strobes", 32'(done_tot - d0), 32'd2);
    chk("R8", "count after", 32'(xfer_count), 32'd0);
  endtask

  task automatic t_halt();
    int b; int d0;
    set_cfg(1, 0, 0, 1, 1, 1, 0);
    load(24'h000F10, 24'h001020, 16'd2);
    script(0, 1, 0, 2);
    b = n_log; d0 = done_tot;
    pulse_req(); idle_wait(6);
    chk("R6", "halted", 32'(st_halted), 32'd1);
    chk("R6", "cycles before", 32'(n_log - b), 32'd2);
    chk("R6", "strobes before", 32'(done_tot - d0), 32'd2);
    chk("R6", "src stepped", 32'(mem_ptr), 32'hF12);
    chk("R6", "count held", 32'(xfer_count), 32'd2);
    pulse_resume(); idle_wait(6);
    chk("R6", "cycles after", 32'(n_log - b), 32'd4);
    chk_cyc("R6", b + 2, 24'h001020, 1, 1, 0);
    chk_wdata("R6", b + 3, 16'h004B);
    chk("R6", "count after", 32'(xfer_count), 32'd1);
    chk("R6", "released", 32'(st_halted), 32'd0);
  endtask

  task automatic t_buserr();
    int b;
    set_cfg(1, 0, 0, 1, 1, 1, 0);
    load(24'h001110, 24'h001220, 16'd5);
    script(0, 4, 0, 2);
    b = n_log;
    pulse_req(); idle_wait(6);
    chk("R9", "error flag", 32'(st_err), 32'd1);
    chk("R9", "cycles", 32'(n_log - b), 32'd2);
    chk("R9", "count held", 32'(xfer_count), 32'd5);
    chk("R9", "ptrs", {mem_ptr[15:0], dev_ptr[15:0]}, 32'h1111_1220);
    pulse_req(); idle_wait(6);
    chk("R9", "req after error", 32'(n_log - b), 32'd2);
    load(24'h000000, 24'h000000, 16'd1);
    chk("R12", "load clears error", 32'(st_err), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_narrow();
    t_word_narrow();
    t_word_mixed();
    t_word_wide();
    t_pack();
    t_retry();
    t_relretry();
    t_halt();
    t_buserr();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule